// File: doc/BRIEF.md
# Equivalent-Time SAR Sweep Controller

This block captures a repetitive waveform one point at a time. For every setting of a sample-delay code it finds the waveform amplitude by a successive-approximation search on a threshold DAC. The comparator is a latched type that evaluates only on a trigger edge. The block therefore fires a fresh trigger pulse for each bit decision, and no track-and-hold is needed in front of the comparator.

A sweep starts on a start pulse. The delay code steps upward from zero through its full range. After each conversion the final DAC code is written to an external waveform store, addressed by the delay code. When the last point has been written, a one-cycle done flag closes the sweep.

Codes are recorded exactly as they are driven to the DAC. If the analog path inverts the threshold, so that code 0 is the highest voltage, that inversion is left to later processing.

Three settle counts are parameters:
- the wait after a new delay code is applied;
- the low time of the trigger before each rising edge, during which the DAC settles;
- the high time of the trigger before the comparator is read.

Together they set the trigger repetition rate.

Top module: `etsar_sweep`

## Requirements
- R1: After reset, trig_o, dac_code_o, delay_code_o, wr_en_o and done_o are all 0.
- R2: A start pulse while idle begins a sweep at delay code 0 with the DAC code cleared. A start pulse during a sweep is ignored and does not disturb the results.
- R3: The delay code takes the values 0, 1, … 2^DLY_W−1 in ascending order, with one conversion per value. It does not change while trig_o is high.
- R4: After the delay code changes, at least SETTLE_CYC clock cycles pass before the first trigger rising edge for that point.
- R5: Each conversion uses exactly DAC_W trigger pulses. Each pulse is high for FIRE_CYC cycles, and comp_i is sampled in the last high cycle.
- R6: Between two trigger pulses of the same point, trig_o is low for exactly ARM_CYC cycles. dac_code_o does not change while trig_o is high.
- R7: Bits are decided from MSB to LSB. The bit under test is set in the trial code. It is kept if comp_i is 1 when sampled and cleared if comp_i is 0. For a comparator that is 1 exactly when the code is at or below a level L, the result is L. The code is stored without inversion.
- R8: wr_en_o is high for exactly one cycle per delay point. In that cycle wr_addr_o equals the delay code and wr_data_o equals the final code.
- R9: trig_o is low during the write cycle and while the delay settles.
- R10: done_o is high for exactly one cycle, the cycle right after the write of the last delay point. No trigger or write follows until the next start.
- R11: A full sweep produces exactly 2^DLY_W × DAC_W trigger pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a sweep (accepted when idle) |
| comp_i | input | 1 | Latched comparator result |
| trig_o | output | 1 | Trigger to pulse driver and comparator latch |
| dac_code_o | output | DAC_W | Trial threshold code |
| delay_code_o | output | DLY_W | Sample delay code |
| wr_en_o | output | 1 | Result write strobe |
| wr_addr_o | output | DLY_W | Result write address |
| wr_data_o | output | DAC_W | Result write data |
| done_o | output | 1 | Sweep finished, one cycle |

## Verification
A wrong bit pointer or a wrong keep/clear decision shows up as a wrong wr_data_o value at the write of the very point where it happens. It also shows as a wrong count of trigger pulses before that write. A sequencer that skips or repeats a state changes the trigger high width or the low gap, and this is visible on the next pulse. A faulty delay counter shows as an out-of-order write address, or as a missing or early done flag within one delay point. The bench runs full sweeps of a small configuration with level profiles that include the code extremes, and compares every stored sample against the level it programmed.

// File: rtl/etsar_pkg.sv
package etsar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_ARM,
        ST_FIRE,
        ST_STORE,
        ST_DONE
    } etsar_state_e;
endpackage

// File: rtl/etsar_wait_timer.sv
module etsar_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = load_val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);

    // R5
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && $past(cnt_q) == '0 && !$past(load_i)) |-> cnt_q == '0);
endmodule

// File: rtl/etsar_sar_reg.sv
module etsar_sar_reg #(
    parameter int DAC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             seed_i,
    input  logic             decide_i,
    input  logic             comp_i,
    output logic [DAC_W-1:0] code_o,
    output logic             last_o
);
    localparam int PTR_W = (DAC_W > 1) ? $clog2(DAC_W) : 1;
    localparam logic [PTR_W-1:0] MSB_PTR = PTR_W'(DAC_W - 1);

    typedef struct packed {
        logic [DAC_W-1:0] code;
        logic [PTR_W-1:0] ptr;
    } sar_st_t;

    sar_st_t st_d, st_q;
    logic [DAC_W-1:0] cur_mask;
    logic [DAC_W-1:0] nxt_mask;

    always_comb begin
        cur_mask = '0;
        nxt_mask = '0;
        for (int i = 0; i < DAC_W; i++) begin
            if (PTR_W'(i) == st_q.ptr)        cur_mask[i] = 1'b1;
            if (PTR_W'(i + 1) == st_q.ptr)    nxt_mask[i] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (clear_i) begin
            st_d.code = '0;
            st_d.ptr  = MSB_PTR;
        end else if (seed_i) begin
            st_d.code = st_q.code | cur_mask;
        end else if (decide_i) begin
            if (!comp_i)
                st_d.code = st_q.code & ~cur_mask;
            if (st_q.ptr != '0) begin
                st_d.code = st_d.code | nxt_mask;
                st_d.ptr  = st_q.ptr - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.code <= '0;
            st_q.ptr  <= MSB_PTR;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign last_o = (st_q.ptr == '0);

    // R7
    keep_on_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_i && !clear_i && comp_i) |=> ((code_o & $past(cur_mask)) != '0));
    // R7
    drop_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (decide_i && !clear_i && !comp_i) |=> ((code_o & $past(cur_mask)) == '0));
endmodule

// File: rtl/etsar_ctrl.sv
module etsar_ctrl
    import etsar_pkg::*;
#(
    parameter int DLY_W      = 10,
    parameter int CNT_W      = 5,
    parameter int SETTLE_CYC = 16,
    parameter int ARM_CYC    = 8,
    parameter int FIRE_CYC   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             expired_i,
    input  logic             last_i,
    output logic             tmr_load_o,
    output logic [CNT_W-1:0] tmr_val_o,
    output logic             sar_clear_o,
    output logic             sar_seed_o,
    output logic             sar_decide_o,
    output logic             trig_o,
    output logic [DLY_W-1:0] delay_o,
    output logic             wr_en_o,
    output logic             done_o
);
    localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
    localparam logic [CNT_W-1:0] ARM_LD    = CNT_W'(ARM_CYC - 1);
    localparam logic [CNT_W-1:0] FIRE_LD   = CNT_W'(FIRE_CYC - 1);
    localparam logic [DLY_W-1:0] DLY_LAST  = '1;

    typedef struct packed {
        etsar_state_e     state;
        logic [DLY_W-1:0] dly;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        tmr_load_o   = 1'b0;
        tmr_val_o    = '0;
        sar_clear_o  = 1'b0;
        sar_seed_o   = 1'b0;
        sar_decide_o = 1'b0;
        unique case (st_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    st_d.dly    = '0;
                    st_d.state  = ST_SETTLE;
                    sar_clear_o = 1'b1;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = SETTLE_LD;
                end
            end
            ST_SETTLE: begin
                if (expired_i) begin
                    st_d.state = ST_ARM;
                    sar_seed_o = 1'b1;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = ARM_LD;
                end
            end
            ST_ARM: begin
                if (expired_i) begin
                    st_d.state = ST_FIRE;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = FIRE_LD;
                end
            end
            ST_FIRE: begin
                if (expired_i) begin
                    sar_decide_o = 1'b1;
                    if (last_i) begin
                        st_d.state = ST_STORE;
                    end else begin
                        st_d.state = ST_ARM;
                        tmr_load_o = 1'b1;
                        tmr_val_o  = ARM_LD;
                    end
                end
            end
            ST_STORE: begin
                if (st_q.dly == DLY_LAST) begin
                    st_d.state = ST_DONE;
                end else begin
                    st_d.dly    = st_q.dly + 1'b1;
                    st_d.state  = ST_SETTLE;
                    sar_clear_o = 1'b1;
                    tmr_load_o  = 1'b1;
                    tmr_val_o   = SETTLE_LD;
                end
            end
            ST_DONE: begin
                st_d.state = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.state <= ST_IDLE;
            st_q.dly   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trig_o  = (st_q.state == ST_FIRE);
    assign wr_en_o = (st_q.state == ST_STORE);
    assign done_o  = (st_q.state == ST_DONE);
    assign delay_o = st_q.dly;

    // R3
    dly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $stable(delay_o));
    // R8
    wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R10
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(wr_en_o) && $past(delay_o) == DLY_LAST));
    // R9
    wr_trig_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> !trig_o);
    // R5
    decide_in_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sar_decide_o |-> trig_o);
endmodule

// File: rtl/etsar_sweep.sv
module etsar_sweep #(
    parameter int DAC_W      = 10,
    parameter int DLY_W      = 10,
    parameter int SETTLE_CYC = 16,
    parameter int ARM_CYC    = 8,
    parameter int FIRE_CYC   = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             comp_i,
    output logic             trig_o,
    output logic [DAC_W-1:0] dac_code_o,
    output logic [DLY_W-1:0] delay_code_o,
    output logic             wr_en_o,
    output logic [DLY_W-1:0] wr_addr_o,
    output logic [DAC_W-1:0] wr_data_o,
    output logic             done_o
);
    localparam int MAX_A   = (SETTLE_CYC > ARM_CYC) ? SETTLE_CYC : ARM_CYC;
    localparam int MAX_CYC = (MAX_A > FIRE_CYC) ? MAX_A : FIRE_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic             tmr_load, tmr_exp;
    logic [CNT_W-1:0] tmr_val;
    logic             sar_clear, sar_seed, sar_decide, sar_last;

    initial begin
        if (SETTLE_CYC < 1 || ARM_CYC < 1 || FIRE_CYC < 1)
            $error("settle counts must be at least 1");
    end

    etsar_ctrl #(
        .DLY_W(DLY_W), .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC),
        .ARM_CYC(ARM_CYC), .FIRE_CYC(FIRE_CYC)
    ) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .expired_i(tmr_exp), .last_i(sar_last),
        .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
        .sar_clear_o(sar_clear), .sar_seed_o(sar_seed), .sar_decide_o(sar_decide),
        .trig_o(trig_o), .delay_o(delay_code_o),
        .wr_en_o(wr_en_o), .done_o(done_o)
    );

    etsar_wait_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .load_i(tmr_load),
        .load_val_i(tmr_val), .expired_o(tmr_exp)
    );

    etsar_sar_reg #(.DAC_W(DAC_W)) sar_i (
        .clk(clk), .rst_n(rst_n), .clear_i(sar_clear), .seed_i(sar_seed),
        .decide_i(sar_decide), .comp_i(comp_i),
        .code_o(dac_code_o), .last_o(sar_last)
    );

    assign wr_addr_o = delay_code_o;
    assign wr_data_o = dac_code_o;

    // R6
    dac_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $stable(dac_code_o));
endmodule

// File: tb/etsar_sweep_tb_top.sv
module etsar_sweep_tb_top;
    localparam int DAC_W  = 4;
    localparam int DLY_W  = 3;
    localparam int SETTLE = 4;
    localparam int ARM    = 2;
    localparam int FIRE   = 3;
    localparam int NPTS   = 1 << DLY_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic comp;
    logic trig, wr_en, done;
    logic [DAC_W-1:0] dac, wr_data;
    logic [DLY_W-1:0] dly, wr_addr;

    int n_chk = 0;
    int n_fail = 0;
    int pattern = 0;
    bit mon_on = 1'b0;

    always #2 clk = ~clk;

    etsar_sweep #(
        .DAC_W(DAC_W), .DLY_W(DLY_W), .SETTLE_CYC(SETTLE),
        .ARM_CYC(ARM), .FIRE_CYC(FIRE)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .comp_i(comp),
        .trig_o(trig), .dac_code_o(dac), .delay_code_o(dly),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
        .done_o(done)
    );

    function automatic int level(int p, int d);
        if (p == 0) return (d * 5 + 3) % 16;
        if (d == 0) return 0;
        if (d == NPTS - 1) return 15;
        return (d * 11) % 16;
    endfunction

    // Comparator model: high while the code is at or below the programmed level.
    assign comp = (int'(dac) <= level(pattern, int'(dly)));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    int exp_addr, rises_pt, hi_cnt, lo_cnt, since_dly, total_rises, done_cnt;
    logic prev_trig, prev_wr, prev_done;
    logic [DLY_W-1:0] prev_dly;

    always @(negedge clk) begin
        if (mon_on) begin
            if (dly != prev_dly) since_dly = 0; else since_dly++;
            if (trig && !prev_trig) begin
                if (rises_pt == 0)
                    check(since_dly >= SETTLE, "R4 settle", since_dly, SETTLE);
                else
                    check(lo_cnt == ARM, "R6 gap", lo_cnt, ARM);
                rises_pt++;
                total_rises++;
                hi_cnt = 0;
            end
            if (!trig && prev_trig) begin
                check(hi_cnt == FIRE, "R5 high width", hi_cnt, FIRE);
                lo_cnt = 0;
            end
            if (trig) hi_cnt++; else lo_cnt++;
            if (wr_en) begin
                check(!prev_wr, "R8 strobe width", 1, 0);
                check(int'(wr_addr) == exp_addr, "R3 order", wr_addr, exp_addr);
                check(int'(wr_data) == level(pattern, int'(wr_addr)), "R7 result",
                      wr_data, level(pattern, int'(wr_addr)));
                check(rises_pt == DAC_W, "R5 pulses", rises_pt, DAC_W);
                check(!trig, "R9 trig in store", trig, 0);
                exp_addr++;
                rises_pt = 0;
            end
            if (done) begin
                done_cnt++;
                check(prev_wr && exp_addr == NPTS, "R10 done timing", exp_addr, NPTS);
                check(!prev_done, "R10 done width", 1, 0);
            end
            prev_trig = trig;
            prev_wr   = wr_en;
            prev_done = done;
            prev_dly  = dly;
        end
    end

    task automatic run_sweep(input int p, input bit poke);
        pattern     = p;
        exp_addr    = 0;
        rises_pt    = 0;
        total_rises = 0;
        done_cnt    = 0;
        hi_cnt      = 0;
        lo_cnt      = 0;
        since_dly   = 0;
        prev_trig   = trig;
        prev_wr     = wr_en;
        prev_done   = done;
        prev_dly    = dly;
        mon_on      = 1'b1;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        // R2: code cleared and delay 0 right after start
        check(dly == '0, "R2 first delay", dly, 0);
        check(dac == '0, "R2 cleared code", dac, 0);
        if (poke) begin
            repeat (40) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int k = 0; k < 2000 && done_cnt == 0; k++) @(negedge clk);
        check(done_cnt == 1, "R10 done seen", done_cnt, 1);
        check(exp_addr == NPTS, "R8 writes per sweep", exp_addr, NPTS);
        check(total_rises == NPTS * DAC_W, "R11 total pulses", total_rises, NPTS * DAC_W);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            check(!trig && !wr_en && !done, "R10 quiet after done", {trig, wr_en, done}, 0);
        end
        mon_on = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(!trig && !wr_en && !done, "R1 reset flags", {trig, wr_en, done}, 0);
        check(dac == '0, "R1 reset code", dac, 0);
        check(dly == '0, "R1 reset delay", dly, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(!trig && !wr_en, "R2 idle without start", {trig, wr_en}, 0);
        run_sweep(0, 1'b0);
        run_sweep(1, 1'b1);
        run_sweep(0, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule